// File: doc/BRIEF.md
# Two-Stage Watchdog Countdown Timer

A down-counter on a small 32-bit register bus that serves as a two-stage system watchdog. Software writes a soft count, enables the timer, and the counter steps down by one on every tick-enable pulse. When it runs out, the block raises an interrupt. The interrupt handler restarts the counter with a shorter hard count while leaving the interrupt pending. If that second count also runs out, the block drives a system reset output.

A keepalive from software has four steps: acknowledge the interrupt by reading the end-of-interrupt register, stop the timer, write the soft count, and start it again. Starting the timer while no interrupt is pending returns the block to its soft stage. The reset output stays high for a fixed number of clock cycles. At the end of that time every register goes back to its disabled default.

Register map (word offsets on `bus_addr`). Offset 0 is the reload value. Offset 1 is the live count. Offset 2 is the run control. Offset 3 is the end-of-interrupt register. Offset 4 is the interrupt status.

Top module: `wdt_two_stage`

## Requirements
- R1: After reset, all readable registers return 0, and `irq` and `sys_reset` are low.
- R2: A write to offset 0 stores the full 32-bit reload value, and a read of offset 0 returns it unchanged. A read of offset 1 returns the live count.
- R3: Writing 3 to control (offset 2) copies the reload value into the count. While control holds 3, the count drops by one on each clock edge where `tick` is high. A read of offset 2 returns the two control bits last written.
- R4: While control holds 2, the count holds its value. Writing 0 to control clears the count and the pending interrupt, and returns the block to the soft stage.
- R5: In the soft stage, the count stepping from 1 to 0 raises `irq` on the following cycle and moves the block to the hard stage. While the interrupt is pending, a read of offset 4 returns 1; otherwise it returns 0.
- R6: A read of offset 3 returns 0 and clears the pending interrupt.
- R7: A count of 0 never decrements and never expires, even with `tick` held high.
- R8: Writing 3 to control while no interrupt is pending returns the block to the soft stage. The next expiry then only interrupts.
- R9: An expiry in the hard stage raises `sys_reset` for exactly RST_CYCLES cycles. After that, all registers read 0 and `irq` is low.
- R10: Bus writes are ignored while `sys_reset` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count-enable pulse |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid during a read access |
| irq | output | 1 | Expiry interrupt, pending level |
| sys_reset | output | 1 | System reset request |

## Verification
The count is tested with random reload values and random tick patterns, each stopped partway through. This separates decrementing only on ticks from decrementing on every cycle, and it shows whether a stop holds the count. Directed runs with `tick` held high check the exact expiry point, including a reload of 0. The stage tracking is tested with two sequences. In the first, a keepalive with the interrupt cleared must give only a second interrupt. In the second, a restart with the interrupt still pending must give a reset of exact length, and writes made during that reset must not take effect.

// File: rtl/wdt_two_stage.sv
module wdt_two_stage #(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 3,
  parameter int RST_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  output logic              sys_reset
);
  localparam int RC_W = $clog2(RST_CYCLES + 1);
  localparam logic [ADDR_W-1:0] A_LOAD = 0, A_CUR = 1, A_CTRL = 2, A_EOI = 3, A_STAT = 4;

  logic [DATA_W-1:0] load_q, cnt_q;
  logic [1:0]        ctrl_q;
  logic              irq_q, hard_q;
  logic [RC_W-1:0]   rst_cnt_q;

  wire wr_en    = bus_sel & bus_wr & ~sys_reset;
  wire rd_en    = bus_sel & ~bus_wr;
  wire ctrl_wr  = wr_en && bus_addr == A_CTRL;
  wire start    = ctrl_wr && bus_wdata[1:0] == 2'b11;
  wire disable_ = ctrl_wr && bus_wdata[1:0] == 2'b00;
  wire running  = ctrl_q == 2'b11;
  wire step     = running & tick & (cnt_q != '0);
  wire expire   = step & (cnt_q == DATA_W'(1));
  wire eoi_rd   = rd_en && bus_addr == A_EOI;
  wire rst_end  = rst_cnt_q == RC_W'(1);

  assign sys_reset = rst_cnt_q != '0;
  assign irq       = irq_q;

  always_comb begin
    bus_rdata = '0;
    if (rd_en)
      case (bus_addr)
        A_LOAD:  bus_rdata = load_q;
        A_CUR:   bus_rdata = cnt_q;
        A_CTRL:  bus_rdata = DATA_W'(ctrl_q);
        A_STAT:  bus_rdata = DATA_W'(irq_q);
        default: bus_rdata = '0;
      endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q <= '0; cnt_q <= '0; ctrl_q <= '0;
      irq_q <= 1'b0; hard_q <= 1'b0; rst_cnt_q <= '0;
    end else if (rst_end) begin
      load_q <= '0; cnt_q <= '0; ctrl_q <= '0;
      irq_q <= 1'b0; hard_q <= 1'b0; rst_cnt_q <= '0;
    end else begin
      if (sys_reset) rst_cnt_q <= rst_cnt_q - RC_W'(1);
      if (wr_en && bus_addr == A_LOAD) load_q <= bus_wdata;
      if (ctrl_wr) ctrl_q <= bus_wdata[1:0];

      if (start)         cnt_q <= load_q;
      else if (disable_) cnt_q <= '0;
      else if (step)     cnt_q <= cnt_q - DATA_W'(1);

      if (disable_)                 irq_q <= 1'b0;
      else if (expire && !hard_q)   irq_q <= 1'b1;
      else if (eoi_rd)              irq_q <= 1'b0;

      if (disable_ || (start && !irq_q)) hard_q <= 1'b0;
      else if (expire)                   hard_q <= 1'b1;

      if (expire && hard_q && !sys_reset) rst_cnt_q <= RC_W'(RST_CYCLES);
    end
  end

  p_irq_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !hard_q && !rst_end && !disable_) |=> (irq && hard_q));
  p_eoi_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_rd && !expire) |=> !irq);
  p_hold_stopped_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q == 2'b10 && !ctrl_wr && !rst_end) |=> $stable(cnt_q));
  p_zero_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && !ctrl_wr) |=> (cnt_q == '0 && !$rose(irq)));
  p_reset_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sys_reset) |-> (load_q == '0 && ctrl_q == '0 && !irq_q));
  p_wr_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_reset && !rst_end) |=> $stable(load_q));
endmodule

// File: tb/tb_wdt_two_stage.sv
module tb_wdt_two_stage;
  localparam int RST_CYCLES = 16;
  logic clk = 0, rst_n = 0, tick = 0;
  logic bus_sel = 0, bus_wr = 0;
  logic [2:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic irq, sys_reset;
  int checks = 0, errors = 0, rst_hi = 0;
  int unsigned seed = 32'h5eed1234;

  wdt_two_stage #(.RST_CYCLES(RST_CYCLES)) dut (.*);

  always #5 clk = ~clk;
  always @(negedge clk) if (sys_reset) rst_hi++;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); tick = 0; bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    @(negedge clk); tick = 0; bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk); bus_sel = 0;
  endtask

  task automatic settle();
    @(negedge clk); tick = 0;
  endtask

  function automatic logic [31:0] expect_after(logic [31:0] l, int ticks);
    return (ticks >= l) ? 32'd0 : l - ticks;
  endfunction

  logic [31:0] v;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    for (int a = 0; a < 5; a++) begin rd(3'(a), v); chk("R1", v, 0); end
    chk("R1 irq", irq, 0); chk("R1 sys_reset", sys_reset, 0);
    // R2 reload readback
    wr(0, 32'hABCD1234); rd(0, v); chk("R2", v, 32'hABCD1234);
    // R3/R4 random count runs
    for (int it = 0; it < 8; it++) begin
      logic [31:0] l; int k, n;
      l = 30 + ($urandom(seed) % 170); seed = seed + 7;
      k = 1 + ($urandom() % 25); n = 0;
      wr(0, l); wr(2, 3);
      for (int c = 0; c < k; c++) begin
        @(negedge clk); tick = $urandom() % 2; if (tick) n++;
      end
      rd(1, v); chk("R3 count", v, expect_after(l, n));
      wr(2, 2);
      for (int c = 0; c < 6; c++) begin @(negedge clk); tick = 1; end
      rd(1, v); chk("R4 hold", v, expect_after(l, n));
      rd(2, v); chk("R3 ctrl", v, 2);
    end
    wr(2, 0); rd(1, v); chk("R4 disable", v, 0);
    // R7 zero load never fires
    wr(0, 0); wr(2, 3);
    for (int c = 0; c < 40; c++) begin @(negedge clk); tick = 1; end
    settle(); chk("R7 irq", irq, 0); rd(1, v); chk("R7 count", v, 0);
    // R5 soft expiry
    wr(0, 5); wr(2, 3);
    for (int c = 0; c < 4; c++) begin @(negedge clk); tick = 1; end
    settle(); chk("R5 not yet", irq, 0);
    @(negedge clk); tick = 1; settle();
    chk("R5 irq", irq, 1); rd(4, v); chk("R5 status", v, 1);
    // R6 end-of-interrupt
    rd(3, v); chk("R6 data", v, 0); chk("R6 irq", irq, 0);
    rd(4, v); chk("R6 status", v, 0);
    // R8 keepalive with irq clear -> soft again
    wr(2, 2); wr(0, 5); wr(2, 3);
    for (int c = 0; c < 5; c++) begin @(negedge clk); tick = 1; end
    settle(); chk("R8 irq", irq, 1); chk("R8 no reset", sys_reset, 0);
    // R9 hard stage: restart while irq pending
    wr(2, 2); wr(0, 4); wr(2, 3);
    rst_hi = 0;
    for (int c = 0; c < 4; c++) begin @(negedge clk); tick = 1; end
    settle(); chk("R9 reset", sys_reset, 1);
    wr(0, 32'h55); rd(0, v); chk("R10 ignored", v, 4);
    for (int c = 0; c < 40 && sys_reset; c++) @(negedge clk);
    chk("R9 length", rst_hi, RST_CYCLES);
    for (int a = 0; a < 5; a++) begin rd(3'(a), v); chk("R9 cleared", v, 0); end
    chk("R9 irq", irq, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule